// File: doc/BRIEF.md
# Serial-Loaded DAC Code Register

This block is the digital front end of a serial-loaded digital-to-analog converter. A host frames a word with an active-low select and shifts it in over a serial clock and a data line, most significant bit first. When select is released, a frame that holds exactly the word width in bits is committed to the output code register, and that register drives the converter core in parallel. A frame of any other length is discarded, and a sticky error flag is raised.

The three serial pins are oversampled by the system clock through a synchronizer chain, so the serial clock must run well below the system clock. An active-low clear input, and the power-on reset, force the code register to a reset code that a parameter selects: zero for a unipolar converter, or mid-scale for a bipolar one.

The committed code leaves as a valid-only stream, `dac_code` qualified by `dac_valid`. There is no ready input, so no back-pressure is possible. Each beat lasts one cycle and the consumer must take it on that cycle. `dac_code` then holds until the next beat or the next clear.

Top module: `serdac_front`

## Requirements
- R1: While `cs_n` is low, each rising edge of `sclk` samples `din`. Bits are taken most significant first, so the first sampled bit lands in `dac_code[15]` and the sixteenth in `dac_code[0]`.
- R2: When `cs_n` rises after exactly 16 rising `sclk` edges since its last fall, the assembled word appears on `dac_code` within SYNC_STAGES+2 system clocks.
- R3: When `cs_n` rises after fewer than 16 `sclk` edges, `dac_code` keeps its previous value and `frame_err` becomes 1.
- R4: When `cs_n` rises after more than 16 `sclk` edges, `dac_code` keeps its previous value and `frame_err` becomes 1.
- R5: `frame_err` stays set across later frames until a frame of exactly 16 bits is accepted, which clears it.
- R6: Toggling `sclk` and `din` while `cs_n` is high changes neither `dac_code` nor `frame_err`, and produces no `dac_valid` pulse.
- R7: `clr_n` low forces `dac_code` to the reset code asynchronously, without waiting for a clock edge. A frame in progress still commits if it completes with 16 bits.
- R8: After `rst_n` is deasserted, `dac_code` equals the reset code and `frame_err` is 0. The reset code is 16'h8000 when BIPOLAR=1 (the default) and 16'h0000 when BIPOLAR=0.
- R9: `dac_valid` is high for exactly one cycle for each accepted frame and is never high for a rejected frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| clr_n | input | 1 | Active-low clear of the code register, asynchronous |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| din | input | 1 | Serial data, most significant bit first |
| dac_code | output | 16 | Committed converter code |
| dac_valid | output | 1 | One-cycle beat marking a newly committed code |
| frame_err | output | 1 | Sticky flag for a frame of the wrong length |

## Verification
A corrupted bit counter shows up on the very next frame end. A valid word is refused and `frame_err` rises, or a short or long frame is accepted and `dac_code` shows the wrong value, within SYNC_STAGES+2 cycles of `cs_n` rising. A shift register that moves while select is high, or that shifts in the wrong direction, gives a wrong committed value on the next accepted frame. A clear path that depends on the clock leaves the old code on `dac_code` in the fraction of a cycle between `clr_n` falling and the next edge.

// File: rtl/serdac_pkg.sv
package serdac_pkg;
  // bit positions of the serial pins inside the synchronized bus
  localparam int PIN_DIN  = 0;
  localparam int PIN_SCLK = 1;
  localparam int PIN_CS_N = 2;
  localparam int PIN_CNT  = 3;

  // idle level of the pins: select high, clock low, data low
  localparam logic [PIN_CNT-1:0] PIN_IDLE = 3'b100;
endpackage

// File: rtl/serdac_sync.sv
module serdac_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] stage [STAGES];
  logic [W-1:0] prev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage[g] <= IDLE;
          else        stage[g] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage[g] <= IDLE;
          else        stage[g] <= stage[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= IDLE;
    else        prev <= stage[STAGES-1];

  assign q    = stage[STAGES-1];
  assign rise = q & ~prev;
  assign fall = ~q & prev;
endmodule

// File: rtl/serdac_shifter.sv
module serdac_shifter #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_lo,
  input  logic              cs_fall,
  input  logic              sclk_rise,
  input  logic              din,
  output logic [DATA_W-1:0] word,
  output logic              count_ok
);
  localparam int CNT_W = $clog2(DATA_W) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);

  logic [CNT_W-1:0] bit_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt <= '0;
      word    <= '0;
    end else if (cs_fall) begin
      bit_cnt <= '0;
    end else if (cs_lo && sclk_rise) begin
      word <= {word[DATA_W-2:0], din};
      // saturate so that long frames never wrap back to the full count
      if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
    end

  assign count_ok = (bit_cnt == CNT_FULL);
endmodule

// File: rtl/serdac_latch.sv
module serdac_latch #(
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] RESET_CODE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              frame_end,
  input  logic              count_ok,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] code,
  output logic              valid,
  output logic              err
);
  logic code_rst_n;
  assign code_rst_n = rst_n & clr_n;

  always_ff @(posedge clk or negedge code_rst_n)
    if (!code_rst_n) begin
      code  <= RESET_CODE;
      valid <= 1'b0;
    end else begin
      valid <= frame_end && count_ok;
      if (frame_end && count_ok) code <= word;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         err <= 1'b0;
    else if (frame_end) err <= !count_ok;
endmodule

// File: rtl/serdac_front.sv
module serdac_front #(
  parameter int DATA_W = 16,
  parameter bit BIPOLAR = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  output logic [DATA_W-1:0] dac_code,
  output logic              dac_valid,
  output logic              frame_err
);
  import serdac_pkg::*;

  localparam logic [DATA_W-1:0] RESET_CODE =
    BIPOLAR ? {1'b1, {(DATA_W-1){1'b0}}} : '0;

  logic [PIN_CNT-1:0] pins_q, pins_rise, pins_fall;
  logic               cs_hi;
  logic [DATA_W-1:0]  shift_q;
  logic               count_ok;

  serdac_sync #(.W(PIN_CNT), .STAGES(SYNC_STAGES), .IDLE(PIN_IDLE)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({cs_n, sclk, din}),
    .q    (pins_q),
    .rise (pins_rise),
    .fall (pins_fall)
  );

  assign cs_hi = pins_q[PIN_CS_N];

  serdac_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_lo    (!cs_hi),
    .cs_fall  (pins_fall[PIN_CS_N]),
    .sclk_rise(pins_rise[PIN_SCLK]),
    .din      (pins_q[PIN_DIN]),
    .word     (shift_q),
    .count_ok (count_ok)
  );

  serdac_latch #(.DATA_W(DATA_W), .RESET_CODE(RESET_CODE)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_n    (clr_n),
    .frame_end(pins_rise[PIN_CS_N]),
    .count_ok (count_ok),
    .word     (shift_q),
    .code     (dac_code),
    .valid    (dac_valid),
    .err      (frame_err)
  );
endmodule

// File: rtl/serdac_front_chk.sv
module serdac_front_chk #(
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] RESET_CODE = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_n,
  input logic              cs_hi,
  input logic [DATA_W-1:0] shift_q,
  input logic [DATA_W-1:0] dac_code,
  input logic              dac_valid,
  input logic              frame_err
);
  // R9: each beat lasts a single cycle
  a_r9_valid_single: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    dac_valid |=> !dac_valid);

  // R9: an accepted frame never coexists with the error flag
  a_r9_valid_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid |-> !frame_err);

  // R3 / R4: the code only moves with a beat or a clear
  a_r3_code_needs_valid: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    !dac_valid |-> $stable(dac_code));

  // R7: clear holds the reset code
  a_r7_clear_code: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> dac_code == RESET_CODE);

  // R6: the shift register holds while select stays high
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_hi && $past(cs_hi)) |-> $stable(shift_q));

  // R5: error flag moves only at frame ends, never while select stays low
  a_r5_err_stable_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_hi && $past(!cs_hi)) |-> $stable(frame_err));
endmodule

bind serdac_front serdac_front_chk #(.DATA_W(DATA_W), .RESET_CODE(RESET_CODE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clr_n    (clr_n),
  .cs_hi    (cs_hi),
  .shift_q  (shift_q),
  .dac_code (dac_code),
  .dac_valid(dac_valid),
  .frame_err(frame_err)
);

// File: tb/serdac_front_tb.sv
module serdac_front_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_n = 1'b1;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        din = 1'b0;
  logic [15:0] dac_code;
  logic        dac_valid;
  logic        frame_err;

  int checks = 0;
  int errors = 0;
  int beats = 0;
  logic [15:0] model;
  logic        done = 1'b0;

  always #2 clk = ~clk;

  serdac_front u_dut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .dac_code(dac_code), .dac_valid(dac_valid), .frame_err(frame_err)
  );

  always @(negedge clk) if (rst_n && dac_valid) beats++;

  // {data, bit count}
  localparam logic [21:0] VEC [8] = '{
    {16'hA5C3, 6'd16}, {16'h1234, 6'd15}, {16'hFFFF, 6'd16}, {16'h0F0F, 6'd17},
    {16'h0001, 6'd16}, {16'hBEEF, 6'd1},  {16'h8000, 6'd16}, {16'h7E81, 6'd20}
  };

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic send(logic [15:0] data, int nbits, bit clear_mid);
    cs_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < nbits; i++) begin
      din = (i < 16) ? data[15-i] : i[0];
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
      if (clear_mid && i == 7) begin
        clr_n = 1'b0;
        #1;
        check("R7 async clear mid-frame", dac_code, 16'h8000);
        wait_clk(2);
        clr_n = 1'b1;
      end
    end
    wait_clk(4);
    cs_n = 1'b1;
    wait_clk(12);
  endtask

  initial begin
    int b0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    check("R8 reset code", dac_code, 16'h8000);
    check("R8 reset err", {15'd0, frame_err}, 16'd0);
    model = 16'h8000;

    for (int v = 0; v < 8; v++) begin
      logic [15:0] d;
      int n;
      d = VEC[v][21:6];
      n = int'(VEC[v][5:0]);
      b0 = beats;
      send(d, n, 1'b0);
      if (n == 16) model = d;
      check(n == 16 ? "R1 R2 accepted word" : (n < 16 ? "R3 short frame hold" : "R4 long frame hold"),
            dac_code, model);
      check(n == 16 ? "R5 err cleared" : "R3 R4 err set", {15'd0, frame_err}, {15'd0, n != 16});
      check("R9 beat count", 16'(beats - b0), (n == 16) ? 16'd1 : 16'd0);
    end

    // R5: error stays through a second bad frame, then clears
    send(16'h4444, 3, 1'b0);
    send(16'h5555, 18, 1'b0);
    check("R5 sticky err", {15'd0, frame_err}, 16'd1);
    send(16'h6DB6, 16, 1'b0);
    check("R5 err cleared by valid", {15'd0, frame_err}, 16'd0);
    check("R1 word MSB first", dac_code, 16'h6DB6);

    // R6: serial activity with select high
    b0 = beats;
    for (int i = 0; i < 20; i++) begin
      din = ~din;
      wait_clk(4);
      sclk = ~sclk;
      wait_clk(4);
    end
    sclk = 1'b0;
    wait_clk(8);
    check("R6 idle code hold", dac_code, 16'h6DB6);
    check("R6 idle err hold", {15'd0, frame_err}, 16'd0);
    check("R6 idle no beat", 16'(beats - b0), 16'd0);

    // R7: asynchronous clear between clock edges
    @(negedge clk);
    #0.5 clr_n = 1'b0;
    #0.5;
    check("R7 async clear", dac_code, 16'h8000);
    wait_clk(2);
    clr_n = 1'b1;
    wait_clk(2);
    check("R7 clear holds", dac_code, 16'h8000);

    // R7: clear in mid-frame, frame still commits
    send(16'h3C5A, 16, 1'b1);
    check("R7 frame after clear", dac_code, 16'h3C5A);

    // R2: latency bound after select rises
    cs_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < 16; i++) begin
      din = i[0];
      wait_clk(4); sclk = 1'b1; wait_clk(4); sclk = 1'b0;
    end
    wait_clk(4);
    cs_n = 1'b1;
    wait_clk(4);
    check("R2 latency", dac_code, 16'h5555);
    wait_clk(4);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule